// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After a start pulse, this block reads a fixed image of eighteen 16-bit words from a three-wire serial EEPROM with a separate chip select. Each word is fetched with its own read command. The block shifts the returned bits in most significant bit first and writes the word into the configuration register that word position maps to. While reading, it adds every byte of the image into an 8-bit modulo-256 sum. It also forms a 16-bit sum over the station-address and identification bytes.

When the last word has arrived, the block decides whether the image can be trusted. The image is accepted only if the 8-bit sum of all 36 bytes equals FFh. An adjust byte stored in the image is chosen to make this true. A rejected image puts the configuration registers back to their reset defaults. In both cases the block raises `done` and holds it until the next start.

The serial clock runs at the system clock divided by the even parameter `DIV`. Chip select drops between words.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: One load issues exactly 18 read frames, to word addresses 0 through 17 in increasing order. Each frame is sent on `ee_do` as the opcode bits 1,1,0 followed by the 6-bit word address, most significant bit first.
- R2: Each frame runs at `ee_cs` high for exactly 26 serial clock periods. `ee_sclk` is high and low for `DIV/2` system clocks each. After the 9 command bits, one dummy bit is skipped. The 16 data bits are then sampled on rising `ee_sclk` edges, and the first data bit becomes bit 15 of the word.
- R3: `ee_sclk` is low whenever `ee_cs` is low. Between frames, `ee_cs` stays low for at least `DIV` system clocks.
- R4: Words 8, 9, 10, 11 and 12 load `cfg_r16`, `cfg_r17`, `cfg_r18`, `cfg_r2` and `cfg_r21` respectively. In each word, the byte at the even byte address is bits 7:0 and the byte at the odd byte address is bits 15:8.
- R5: Words 0 to 2 form `station_addr`, with byte address n placed at bits 8n+7:8n. The first byte on the medium is therefore `station_addr[7:0]`.
- R6: `valid` is 1 at the end of a load exactly when the modulo-256 sum of all 36 image bytes is FFh.
- R7: `csum16` is the 16-bit sum of bytes 00h–0Bh and bytes 0Eh–0Fh. `csum16_match` is 1 when this sum equals word 6, taken as byte 0Ch low and byte 0Dh high. This flag does not affect `valid`.
- R8: If the byte sum is not FFh, the five configuration registers return to their parameter defaults and `station_addr` returns to 0. In that case `valid` stays 0 and `done` still rises.
- R9: A start pulse during a load is ignored, and the load completes with 18 frames. `done` stays high until the next start, and that start clears `done` and `valid` in the following cycle.
- R10: Out of reset, `ee_cs`, `ee_sclk`, `done` and `valid` are 0, and the configuration registers hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a load |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Command bits to the EEPROM |
| ee_di | input | 1 | Data bits from the EEPROM |
| done | output | 1 | Load finished; held until the next start |
| valid | output | 1 | Image byte sum equalled FFh |
| cfg_r16 | output | 16 | Configuration register loaded from word 8 |
| cfg_r17 | output | 16 | Configuration register loaded from word 9 |
| cfg_r18 | output | 16 | Configuration register loaded from word 10 |
| cfg_r2 | output | 16 | Configuration register loaded from word 11 |
| cfg_r21 | output | 16 | Configuration register loaded from word 12 |
| station_addr | output | 48 | Six-byte station address from words 0 to 2 |
| csum16 | output | 16 | Computed 16-bit sum of the address and identification bytes |
| csum16_match | output | 1 | `csum16` equals the stored word 6 |

## Verification
A behavioural EEPROM answers each frame from an image array. It also checks the opcode, the address order, the serial clock phase lengths and the chip-select gaps. Several pseudo-random images are built with a correct adjust byte; they show that each word lands in the right register with the right byte order. The same image is then corrupted with a single-bit error in each of the 36 byte positions in turn, which shows that every byte takes part in the sum and that rejection restores the defaults. One image keeps a correct byte sum but carries a wrong stored 16-bit sum, which separates the two checks. A second start in the middle of a load, and a long wait after `done`, exercise the handshake.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam int WORD_W     = 16;
  localparam int IMG_WORDS  = 18;
  localparam int ADDR_W     = 6;
  localparam int OP_W       = 3;
  localparam int CMD_BITS   = OP_W + ADDR_W;
  localparam int FIRST_DATA = CMD_BITS + 1;
  localparam int FRAME_BITS = FIRST_DATA + WORD_W;
  localparam int IDX_W      = $clog2(IMG_WORDS);
  localparam int N_CFG      = 5;
  localparam int N_STA      = 3;
  localparam int CSUM_WORD  = 6;
  localparam logic [OP_W-1:0] RD_OP = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_CHECK, S_DONE} seq_t;
  typedef enum logic [1:0] {R_IDLE, R_XFER, R_GAP} rd_t;

  function automatic logic [7:0] word_bytes8(input logic [WORD_W-1:0] w);
    return w[7:0] + w[15:8];
  endfunction

  function automatic logic [15:0] word_bytes16(input logic [WORD_W-1:0] w);
    return {8'h00, w[7:0]} + {8'h00, w[15:8]};
  endfunction

  function automatic logic in_csum16_set(input logic [IDX_W-1:0] idx);
    return (idx <= IDX_W'(5)) || (idx == IDX_W'(7));
  endfunction

  function automatic logic [IDX_W-1:0] cfg_slot_word(input int slot);
    return IDX_W'(8 + slot);
  endfunction

  function automatic logic [CMD_BITS-1:0] read_cmd(input logic [ADDR_W-1:0] a);
    return {RD_OP, a};
  endfunction
endpackage

// File: rtl/ee_serial_reader.sv
module ee_serial_reader
  import eecfg_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ee_di,
  output logic              ee_cs,
  output logic              ee_sclk,
  output logic              ee_do,
  output logic              rd_busy,
  output logic              word_strobe,
  output logic [WORD_W-1:0] word_data
);
  localparam int HALF = DIV / 2;
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GC_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BI_W = $clog2(FRAME_BITS);

  rd_t               state;
  logic [HC_W-1:0]   half_cnt;
  logic [GC_W-1:0]   gap_cnt;
  logic [BI_W-1:0]   bit_idx;
  logic [CMD_BITS-1:0] cmd_q;
  logic [WORD_W-1:0] shreg;
  logic              half_tick;
  logic              rise_now;
  logic              fall_now;
  logic              data_bit;
  logic              last_bit;

  assign half_tick = (state == R_XFER) && (half_cnt == HC_W'(HALF - 1));
  assign rise_now  = half_tick && !ee_sclk;
  assign fall_now  = half_tick && ee_sclk;
  assign data_bit  = (bit_idx >= BI_W'(FIRST_DATA));
  assign last_bit  = (bit_idx == BI_W'(FRAME_BITS - 1));

  always_comb begin
    ee_do = 1'b0;
    if (state == R_XFER && bit_idx < BI_W'(CMD_BITS))
      ee_do = cmd_q[CMD_BITS - 1 - int'(bit_idx)];
  end

  assign rd_busy   = (state != R_IDLE);
  assign word_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= R_IDLE;
      half_cnt    <= '0;
      gap_cnt     <= '0;
      bit_idx     <= '0;
      cmd_q       <= '0;
      shreg       <= '0;
      ee_cs       <= 1'b0;
      ee_sclk     <= 1'b0;
      word_strobe <= 1'b0;
    end else begin
      word_strobe <= 1'b0;
      case (state)
        R_IDLE: begin
          if (req) begin
            state    <= R_XFER;
            cmd_q    <= read_cmd(addr);
            bit_idx  <= '0;
            half_cnt <= '0;
            ee_cs    <= 1'b1;
            ee_sclk  <= 1'b0;
          end
        end
        R_XFER: begin
          if (half_tick) half_cnt <= '0;
          else           half_cnt <= half_cnt + 1'b1;
          if (rise_now) begin
            ee_sclk <= 1'b1;
            if (data_bit) shreg <= {shreg[WORD_W-2:0], ee_di};
          end
          if (fall_now) begin
            ee_sclk <= 1'b0;
            if (last_bit) begin
              state       <= R_GAP;
              ee_cs       <= 1'b0;
              gap_cnt     <= '0;
              word_strobe <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        R_GAP: begin
          if (gap_cnt == GC_W'(DIV - 1)) state <= R_IDLE;
          else                           gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ee_image_sum.sv
module ee_image_sum
  import eecfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              word_strobe,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  output logic [7:0]        sum8,
  output logic [15:0]       sum16,
  output logic [15:0]       stored16
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum8     <= '0;
      sum16    <= '0;
      stored16 <= '0;
    end else if (clear) begin
      sum8     <= '0;
      sum16    <= '0;
      stored16 <= '0;
    end else if (word_strobe) begin
      sum8 <= sum8 + word_bytes8(word_data);
      if (in_csum16_set(word_idx)) sum16 <= sum16 + word_bytes16(word_data);
      if (word_idx == IDX_W'(CSUM_WORD)) stored16 <= word_data;
    end
  end
endmodule

// File: rtl/ee_cfg_regs.sv
module ee_cfg_regs
  import eecfg_pkg::*;
#(
  parameter logic [N_CFG-1:0][WORD_W-1:0] DEFAULTS = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               word_idx,
  input  logic [WORD_W-1:0]              word_data,
  input  logic                           restore,
  output logic [N_CFG-1:0][WORD_W-1:0]   cfg_q,
  output logic [N_STA-1:0][WORD_W-1:0]   sta_q
);
  for (genvar s = 0; s < N_CFG; s++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       cfg_q[s] <= DEFAULTS[s];
      else if (restore)                                 cfg_q[s] <= DEFAULTS[s];
      else if (wr_en && word_idx == cfg_slot_word(s))   cfg_q[s] <= word_data;
    end
  end

  for (genvar w = 0; w < N_STA; w++) begin : g_sta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sta_q[w] <= '0;
      else if (restore)                            sta_q[w] <= '0;
      else if (wr_en && word_idx == IDX_W'(w))     sta_q[w] <= word_data;
    end
  end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int          DIV     = 8,
  parameter logic [15:0] DEF_R16 = 16'h0000,
  parameter logic [15:0] DEF_R17 = 16'h0000,
  parameter logic [15:0] DEF_R18 = 16'h9001,
  parameter logic [15:0] DEF_R2  = 16'h0002,
  parameter logic [15:0] DEF_R21 = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        ee_cs,
  output logic        ee_sclk,
  output logic        ee_do,
  input  logic        ee_di,
  output logic        done,
  output logic        valid,
  output logic [15:0] cfg_r16,
  output logic [15:0] cfg_r17,
  output logic [15:0] cfg_r18,
  output logic [15:0] cfg_r2,
  output logic [15:0] cfg_r21,
  output logic [47:0] station_addr,
  output logic [15:0] csum16,
  output logic        csum16_match
);
  localparam logic [N_CFG-1:0][WORD_W-1:0] DEFAULTS =
    {DEF_R21, DEF_R2, DEF_R18, DEF_R17, DEF_R16};

  seq_t              state;
  logic [IDX_W-1:0]  word_idx;
  logic              rd_busy;
  logic              rd_req;
  logic              word_strobe;
  logic [WORD_W-1:0] word_data;
  logic              sum_clear;
  logic              restore;
  logic              seq_busy;
  logic              start_ok;
  logic [7:0]        sum8;
  logic [15:0]       stored16;
  logic [N_CFG-1:0][WORD_W-1:0] cfg_q;
  logic [N_STA-1:0][WORD_W-1:0] sta_q;

  assign seq_busy  = (state == S_REQ) || (state == S_WAIT) || (state == S_CHECK);
  assign start_ok  = start && !seq_busy;
  assign sum_clear = start_ok;
  assign rd_req    = (state == S_REQ) && !rd_busy;
  assign restore   = (state == S_CHECK) && (sum8 != 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      word_idx <= '0;
      done     <= 1'b0;
      valid    <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start_ok) begin
            state    <= S_REQ;
            word_idx <= '0;
            done     <= 1'b0;
            valid    <= 1'b0;
          end
        end
        S_REQ: if (rd_req) state <= S_WAIT;
        S_WAIT: begin
          if (word_strobe) begin
            if (word_idx == IDX_W'(IMG_WORDS - 1)) begin
              state <= S_CHECK;
            end else begin
              word_idx <= word_idx + 1'b1;
              state    <= S_REQ;
            end
          end
        end
        S_CHECK: begin
          done  <= 1'b1;
          valid <= (sum8 == 8'hFF);
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  ee_serial_reader #(.DIV(DIV)) u_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (rd_req),
    .addr       (ADDR_W'(word_idx)),
    .ee_di      (ee_di),
    .ee_cs      (ee_cs),
    .ee_sclk    (ee_sclk),
    .ee_do      (ee_do),
    .rd_busy    (rd_busy),
    .word_strobe(word_strobe),
    .word_data  (word_data)
  );

  ee_image_sum u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (sum_clear),
    .word_strobe(word_strobe),
    .word_idx   (word_idx),
    .word_data  (word_data),
    .sum8       (sum8),
    .sum16      (csum16),
    .stored16   (stored16)
  );

  ee_cfg_regs #(.DEFAULTS(DEFAULTS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (word_strobe),
    .word_idx (word_idx),
    .word_data(word_data),
    .restore  (restore),
    .cfg_q    (cfg_q),
    .sta_q    (sta_q)
  );

  assign cfg_r16      = cfg_q[0];
  assign cfg_r17      = cfg_q[1];
  assign cfg_r18      = cfg_q[2];
  assign cfg_r2       = cfg_q[3];
  assign cfg_r21      = cfg_q[4];
  assign station_addr = {sta_q[2], sta_q[1], sta_q[0]};
  assign csum16_match = (csum16 == stored16);
endmodule

// File: rtl/ee_loader_checker.sv
module ee_loader_checker
  import eecfg_pkg::*;
#(
  parameter int          DIV     = 8,
  parameter logic [15:0] DEF_R16 = 16'h0000,
  parameter logic [15:0] DEF_R17 = 16'h0000,
  parameter logic [15:0] DEF_R18 = 16'h0000,
  parameter logic [15:0] DEF_R2  = 16'h0000,
  parameter logic [15:0] DEF_R21 = 16'h0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ee_cs,
  input logic             ee_sclk,
  input logic             done,
  input logic             valid,
  input logic             seq_busy,
  input logic [IDX_W-1:0] word_idx,
  input logic [7:0]       sum8,
  input logic [15:0]      cfg_r16,
  input logic [15:0]      cfg_r17,
  input logic [15:0]      cfg_r18,
  input logic [15:0]      cfg_r2,
  input logic [15:0]      cfg_r21,
  input logic [47:0]      station_addr
);
  localparam int LC_W = $clog2(DIV + 1);
  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= LC_W'(DIV);
    else if (ee_cs)                      low_cnt <= '0;
    else if (low_cnt != LC_W'(DIV))      low_cnt <= low_cnt + 1'b1;
  end

  a_r3_sclk_low_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sclk);
  a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> low_cnt == LC_W'(DIV));
  a_r10_cs_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !ee_cs);
  a_r1_word_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    word_idx < IDX_W'(IMG_WORDS));
  a_r9_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_busy && done));
  a_r9_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r8_valid_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);
  a_r6_valid_from_sum: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> valid == (sum8 == 8'hFF));
  a_r8_defaults_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |-> (cfg_r16 == DEF_R16 && cfg_r17 == DEF_R17 &&
                          cfg_r18 == DEF_R18 && cfg_r2 == DEF_R2 &&
                          cfg_r21 == DEF_R21 && station_addr == 48'h0));
endmodule

bind eeprom_cfg_loader ee_loader_checker #(
  .DIV(DIV), .DEF_R16(DEF_R16), .DEF_R17(DEF_R17), .DEF_R18(DEF_R18),
  .DEF_R2(DEF_R2), .DEF_R21(DEF_R21)
) u_chk (.*);

// File: tb/eeprom_cfg_loader_bench.sv
module eeprom_cfg_loader_bench;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam logic [15:0] D16 = 16'hA5C3, D17 = 16'h1E2D, D18 = 16'h9001,
                          D2 = 16'h0042, D21 = 16'h7F08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ee_cs, ee_sclk, ee_do;
  logic ee_di = 1'b0;
  logic done, valid, csum16_match;
  logic [15:0] cfg_r16, cfg_r17, cfg_r18, cfg_r2, cfg_r21, csum16;
  logic [47:0] station_addr;

  always #10 clk = ~clk;

  eeprom_cfg_loader #(.DIV(DIV), .DEF_R16(D16), .DEF_R17(D17), .DEF_R18(D18),
                      .DEF_R2(D2), .DEF_R21(D21)) u_eeprom_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .ee_cs(ee_cs), .ee_sclk(ee_sclk),
    .ee_do(ee_do), .ee_di(ee_di), .done(done), .valid(valid),
    .cfg_r16(cfg_r16), .cfg_r17(cfg_r17), .cfg_r18(cfg_r18), .cfg_r2(cfg_r2),
    .cfg_r21(cfg_r21), .station_addr(station_addr), .csum16(csum16),
    .csum16_match(csum16_match));

  int total = 0;
  int bad = 0;
  logic [15:0] mem [0:17];

  // EEPROM model, evaluated on falling system clock edges
  int err_r1 = 0, err_r2 = 0, err_r3 = 0, frames = 0;
  int rise_n = 0, hcnt = 0, cslow = 1000, exp_addr = 0;
  logic [8:0] cmd = '0;
  logic sclk_q = 1'b0, cs_q = 1'b0;

  always @(negedge clk) begin
    if (ee_cs && !cs_q) begin
      if (cslow < DIV) err_r3++;
      rise_n = 0; hcnt = 1; cmd = '0;
    end else if (ee_cs) begin
      if (ee_sclk != sclk_q) begin
        if (hcnt != HALF) err_r2++;
        hcnt = 1;
        if (ee_sclk) begin
          rise_n++;
          if (rise_n <= 9) cmd = {cmd[7:0], ee_do};
          if (rise_n == 9) begin
            if (cmd[8:6] != 3'b110 || int'(cmd[5:0]) != exp_addr) err_r1++;
            exp_addr = (exp_addr == 17) ? 0 : exp_addr + 1;
            frames++;
          end
        end else if (rise_n == 9) begin
          ee_di <= 1'b0;
        end else if (rise_n >= 10 && rise_n < 26) begin
          ee_di <= mem[cmd[5:0]][15 - (rise_n - 10)];
        end
      end else begin
        hcnt++;
      end
    end
    if (!ee_cs) begin
      if (cs_q && rise_n != 26) err_r2++;
      if (ee_sclk) err_r3++;
      if (cslow < 1000) cslow++;
    end else begin
      cslow = 0;
    end
    sclk_q = ee_sclk;
    cs_q = ee_cs;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] get_b(input int b);
    return b[0] ? mem[b >> 1][15:8] : mem[b >> 1][7:0];
  endfunction

  task automatic set_b(input int b, input logic [7:0] v);
    if (b[0]) mem[b >> 1][15:8] = v; else mem[b >> 1][7:0] = v;
  endtask

  function automatic logic [15:0] exp_csum16();
    logic [15:0] s = 0;
    for (int b = 0; b < 16; b++)
      if (b < 12 || b > 13) s = s + 16'(get_b(b));
    return s;
  endfunction

  function automatic logic [7:0] all_sum();
    int s = 0;
    for (int b = 0; b < 36; b++) s += int'(get_b(b));
    return 8'(s);
  endfunction

  task automatic make_image(input int seed);
    int x = seed * 7919 + 13;
    int s = 0;
    for (int w = 0; w < 18; w++) begin
      x = (x * 1103515245 + 12345) & 32'h7FFFFFFF;
      mem[w] = 16'(x >> 7);
    end
    mem[6] = exp_csum16();
    for (int b = 0; b < 36; b++) if (b != 8'h1F) s += int'(get_b(b));
    set_b(8'h1F, 8'(8'hFF - 8'(s)));
  endtask

  task automatic run_load();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string ctx, input int f0, input int e1, input int e2, input int e3);
    logic ok = (all_sum() == 8'hFF);
    chk({ctx, " R6 valid"}, 64'(valid), 64'(ok));
    chk({ctx, " R8 done"}, 64'(done), 64'd1);
    chk({ctx, " R4 cfg_r16"}, 64'(cfg_r16), 64'(ok ? mem[8]  : D16));
    chk({ctx, " R4 cfg_r17"}, 64'(cfg_r17), 64'(ok ? mem[9]  : D17));
    chk({ctx, " R4 cfg_r18"}, 64'(cfg_r18), 64'(ok ? mem[10] : D18));
    chk({ctx, " R4 cfg_r2"},  64'(cfg_r2),  64'(ok ? mem[11] : D2));
    chk({ctx, " R8 cfg_r21"}, 64'(cfg_r21), 64'(ok ? mem[12] : D21));
    chk({ctx, " R5 station"}, 64'(station_addr),
        ok ? 64'({get_b(5), get_b(4), get_b(3), get_b(2), get_b(1), get_b(0)}) : 64'd0);
    chk({ctx, " R7 csum16"}, 64'(csum16), 64'(exp_csum16()));
    chk({ctx, " R7 match"}, 64'(csum16_match), 64'(exp_csum16() == {get_b(13), get_b(12)}));
    chk({ctx, " R1 frames"}, 64'(frames - f0), 64'd18);
    chk({ctx, " R1 cmd/addr"}, 64'(err_r1 - e1), 64'd0);
    chk({ctx, " R2 timing"}, 64'(err_r2 - e2), 64'd0);
    chk({ctx, " R3 cs gap"}, 64'(err_r3 - e3), 64'd0);
  endtask

  initial begin
    int f0, e1, e2, e3;
    repeat (3) @(negedge clk);
    chk("R10 reset cs", 64'(ee_cs), 64'd0);
    chk("R10 reset sclk", 64'(ee_sclk), 64'd0);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset valid", 64'(valid), 64'd0);
    chk("R10 reset cfg", 64'({cfg_r16, cfg_r17, cfg_r18, cfg_r21}), 64'({D16, D17, D18, D21}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int sd = 1; sd <= 6; sd++) begin
      make_image(sd);
      f0 = frames; e1 = err_r1; e2 = err_r2; e3 = err_r3;
      run_load();
      check_all($sformatf("R2 good seed%0d", sd), f0, e1, e2, e3);
    end

    for (int b = 0; b < 36; b++) begin
      make_image(100 + b);
      set_b(b, get_b(b) ^ 8'(1 << (b % 8)));
      f0 = frames; e1 = err_r1; e2 = err_r2; e3 = err_r3;
      run_load();
      check_all($sformatf("R8 flip byte%0d", b), f0, e1, e2, e3);
      chk($sformatf("R6 flip byte%0d rejected", b), 64'(valid), 64'd0);
    end

    make_image(77);
    set_b(12, get_b(12) + 8'd1);
    set_b(8'h1F, get_b(8'h1F) - 8'd1);
    f0 = frames; e1 = err_r1; e2 = err_r2; e3 = err_r3;
    run_load();
    check_all("R7 bad stored sum", f0, e1, e2, e3);
    chk("R7 mismatch keeps valid", 64'({valid, csum16_match}), 64'b10);

    make_image(55);
    f0 = frames; e1 = err_r1; e2 = err_r2; e3 = err_r3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (600) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check_all("R9 restart ignored", f0, e1, e2, e3);

    repeat (100) @(negedge clk);
    chk("R9 done held", 64'(done), 64'd1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 start clears done/valid", 64'({done, valid}), 64'd0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 reload valid", 64'(valid), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule